// File: doc/BRIEF.md
# AEGIS-128 State Update Round

This block computes one state update step of the AEGIS-128 authenticated cipher. The state is five 128-bit words. Each word is passed through one keyless AES round, and the result is folded into the word that follows it. The message word is mixed into word 0 only. All five rounds read the state as it was before the update, so the step is a pure function of its inputs.

The result is captured in an output register when the input strobe is high. A valid flag follows one cycle later. The register keeps its value until the next strobe. A sequencer outside the block drives the initialisation, data and finalisation steps by feeding each result back in as the next input. Padding, length encoding and tag comparison are left to that sequencer.

Top module: `aegis_update_round`

## Requirements
- R1: State word k occupies bits [128k+127:128k] of the state ports (k = 0..4). Byte j of a word occupies bits [8j+7:8j]. The message word uses the same byte layout.
- R2: For k = 1..4, result word k equals input word k XOR R(input word k-1).
- R3: Result word 0 equals input word 0 XOR R(input word 4) XOR the message word. R(input word 4) uses the pre-update word 4.
- R4: R is one AES round with an all-zero round key, applied in this order: row shift, byte substitution, column mix. In the row shift, output byte i takes input byte (0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11)[i]. In the column mix, each column of 4 bytes a0..a3 becomes bytes 2a_j ^ 3a_(j+1) ^ a_(j+2) ^ a_(j+3) in GF(2^8) modulo 0x11b, with indices taken mod 4.
- R5: Byte substitution is the standard AES forward S-box, for example 0x00 to 0x63, 0x01 to 0x7c and 0x53 to 0xed.
- R6: valid_o is high exactly in the cycle after a cycle with valid_i high, and low otherwise.
- R7: While valid_i is low, state_o does not change, whatever the state and message inputs do.
- R8: While rst_ni is low, valid_o is 0 and state_o is all zero. Reset takes effect without waiting for a clock edge.
- R9: An all-zero state with an all-zero message produces 0x63 in every byte of all five result words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the update result |
| state_i | input | 640 | Five pre-update state words, word 0 in the low bits |
| msg_i | input | 128 | Message word mixed into word 0 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| state_o | output | 640 | Registered updated state words |

## Verification
The assertions assume that state_i and msg_i are stable and known in any cycle where valid_i is high. The bench meets this by changing inputs only on the falling clock edge. The hold check assumes nothing about the inputs, so the bench changes them freely while the strobe is low. Random state and message words from a fixed seed are mixed with directed words: all zeros, a repeated byte and a single set byte. A bench model builds its S-box by exhaustive inverse search and checks every result word against it.

// File: rtl/aegis_upd_pkg.sv
`timescale 1ns/1ps
package aegis_upd_pkg;
  localparam int NUM_WORDS  = 5;
  localparam int WORD_W     = 128;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int COL_BYTES  = 4;
  localparam int STATE_W    = NUM_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t xtime(input byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction
endpackage

// File: rtl/aegis_sbox.sv
`timescale 1ns/1ps
module aegis_sbox
  import aegis_upd_pkg::*;
(
  input  byte_t byte_i,
  output byte_t byte_o
);
  byte_t sq, inv;

  // inverse as x^254 = prod of x^(2^i), i=1..7; 0 maps to 0
  always_comb begin
    sq  = byte_i;
    inv = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    byte_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aegis_aes_round.sv
`timescale 1ns/1ps
module aegis_aes_round
  import aegis_upd_pkg::*;
(
  input  word_t word_i,
  output word_t word_o
);
  byte_t shr [WORD_BYTES];
  byte_t sub [WORD_BYTES];
  byte_t mx1 [WORD_BYTES];

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    localparam int SRC = (b + COL_BYTES * (b % COL_BYTES)) % WORD_BYTES;
    localparam int COL = b / COL_BYTES;
    localparam int J   = b % COL_BYTES;
    localparam int OPP = COL * COL_BYTES + (J + 2) % COL_BYTES;
    localparam int NXT = COL * COL_BYTES + (J + 1) % COL_BYTES;

    assign shr[b] = word_i[SRC*BYTE_W +: BYTE_W];

    aegis_sbox u_sbox (
      .byte_i (shr[b]),
      .byte_o (sub[b])
    );

    // doubled byte plus the byte two places away in the column
    assign mx1[b] = xtime(sub[b]) ^ sub[OPP];
    // fold in the neighbour's (v ^ w), giving 3x of the next byte
    assign word_o[b*BYTE_W +: BYTE_W] = mx1[b] ^ sub[NXT] ^ mx1[NXT];
  end
endmodule

// File: rtl/aegis_update_core.sv
`timescale 1ns/1ps
module aegis_update_core
  import aegis_upd_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  word_t              msg_i,
  output logic [STATE_W-1:0] state_o
);
  word_t rnd [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    localparam int PREV = (k + NUM_WORDS - 1) % NUM_WORDS;

    aegis_aes_round u_round (
      .word_i (state_i[k*WORD_W +: WORD_W]),
      .word_o (rnd[k])
    );

    if (k == 0) begin : g_inject
      assign state_o[k*WORD_W +: WORD_W] = state_i[k*WORD_W +: WORD_W] ^ rnd[PREV] ^ msg_i;
    end else begin : g_chain
      assign state_o[k*WORD_W +: WORD_W] = state_i[k*WORD_W +: WORD_W] ^ rnd[PREV];
    end
  end
endmodule

// File: rtl/aegis_update_round.sv
`timescale 1ns/1ps
module aegis_update_round
  import aegis_upd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [WORD_W-1:0]  msg_i,
  output logic               valid_o,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] next_state;
  logic [STATE_W-1:0] state_q;
  logic               valid_q;

  aegis_update_core u_core (
    .state_i (state_i),
    .msg_i   (msg_i),
    .state_o (next_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      state_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) state_q <= next_state;
    end
  end

  assign valid_o = valid_q;
  assign state_o = state_q;
endmodule

// File: rtl/aegis_update_round_chk.sv
`timescale 1ns/1ps
module aegis_update_round_chk
  import aegis_upd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [STATE_W-1:0] state_i,
  input logic [WORD_W-1:0]  msg_i,
  input logic               valid_o,
  input logic [STATE_W-1:0] state_o
);
  localparam logic [STATE_W-1:0] ZERO_IMG = {(STATE_W/BYTE_W){8'h63}};

  p_reset_clear_r8: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && state_o == '0));

  p_valid_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));

  p_zero_image_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_i == '0 && msg_i == '0) |=> state_o == ZERO_IMG);
endmodule

bind aegis_update_round aegis_update_round_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .state_i (state_i),
  .msg_i   (msg_i),
  .valid_o (valid_o),
  .state_o (state_o)
);

// File: tb/aegis_update_round_test.sv
`timescale 1ns/1ps
module aegis_update_round_test;
  localparam int NW = 5;
  localparam int WW = 128;
  localparam int SW = NW * WW;
  localparam int N_RAND = 150;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [SW-1:0] state_i = '0;
  logic [WW-1:0] msg_i = '0;
  logic          valid_o;
  logic [SW-1:0] state_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] sbox_tab [256];

  always #10 clk_i = ~clk_i;

  aegis_update_round uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .state_i (state_i),
    .msg_i   (msg_i),
    .valid_o (valid_o),
    .state_o (state_o)
  );

  function automatic logic [7:0] mul_ref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] sbox_ref(input logic [7:0] x);
    logic [7:0] inv, s;
    inv = '0;
    for (int y = 1; y < 256; y++) if (mul_ref(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
    return s;
  endfunction

  function automatic logic [WW-1:0] round_ref(input logic [WW-1:0] w);
    int shift_map [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    logic [WW-1:0] r;
    for (int i = 0; i < 16; i++) t[i] = sbox_tab[w[shift_map[i]*8 +: 8]];
    for (int c = 0; c < 4; c++) begin
      a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
      r[(4*c)*8   +: 8] = mul_ref(a0,8'd2) ^ mul_ref(a1,8'd3) ^ a2 ^ a3;
      r[(4*c+1)*8 +: 8] = mul_ref(a1,8'd2) ^ mul_ref(a2,8'd3) ^ a3 ^ a0;
      r[(4*c+2)*8 +: 8] = mul_ref(a2,8'd2) ^ mul_ref(a3,8'd3) ^ a0 ^ a1;
      r[(4*c+3)*8 +: 8] = mul_ref(a3,8'd2) ^ mul_ref(a0,8'd3) ^ a1 ^ a2;
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] update_ref(input logic [SW-1:0] s, input logic [WW-1:0] m);
    logic [SW-1:0] n;
    n[0 +: WW] = s[0 +: WW] ^ round_ref(s[4*WW +: WW]) ^ m;
    for (int k = 1; k < NW; k++) n[k*WW +: WW] = s[k*WW +: WW] ^ round_ref(s[(k-1)*WW +: WW]);
    return n;
  endfunction

  function automatic logic [WW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input logic [SW-1:0] exp);
    for (int k = 0; k < NW; k++)
      chk(k == 0 ? "R3 word0" : "R2 wordk", state_o[k*WW +: WW], exp[k*WW +: WW]);
  endtask

  // drive on falling edge, capture at the rising edge, sample on next falling edge
  task automatic step(input logic [SW-1:0] s, input logic [WW-1:0] m);
    @(negedge clk_i);
    state_i = s; msg_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R6 valid_o high", WW'(valid_o), WW'(1));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [SW-1:0] s, exp, held;
    logic [WW-1:0] m;
    void'($urandom(32'h5eed_a361));
    for (int i = 0; i < 256; i++) sbox_tab[i] = sbox_ref(8'(i));

    repeat (3) @(negedge clk_i);
    chk("R8 reset valid_o", WW'(valid_o), '0);
    for (int k = 0; k < NW; k++) chk("R8 reset state_o", state_o[k*WW +: WW], '0);
    rst_ni = 1'b1;

    // R9: all-zero input
    step('0, '0);
    for (int k = 0; k < NW; k++) chk("R9 zero image", state_o[k*WW +: WW], {16{8'h63}});

    // R5: repeated byte through round keeps byte constant
    s = '0; s[0 +: WW] = {16{8'h53}};
    step(s, '0);
    chk("R5 sbox 53->ed", state_o[WW +: WW], {16{8'hed}});
    s = '0; s[0 +: WW] = {16{8'h01}};
    step(s, '0);
    chk("R5 sbox 01->7c", state_o[WW +: WW], {16{8'h7c}});

    // R1: single byte placement in word 0 and word 4
    s = '0; s[8 +: 8] = 8'h01; s[4*WW + 120 +: 8] = 8'h80;
    step(s, '0);
    exp = update_ref(s, '0);
    for (int k = 0; k < NW; k++) chk("R1 byte layout", state_o[k*WW +: WW], exp[k*WW +: WW]);

    // R4: random word 0 alone, word 1 shows R(word 0)
    for (int t = 0; t < 4; t++) begin
      s = '0; s[0 +: WW] = rnd128();
      step(s, '0);
      chk("R4 round", state_o[WW +: WW], round_ref(s[0 +: WW]));
    end

    // R3: message only in word 0
    m = rnd128();
    step('0, m);
    chk("R3 msg inject", state_o[0 +: WW], {16{8'h63}} ^ m);
    for (int k = 1; k < NW; k++) chk("R3 msg isolated", state_o[k*WW +: WW], {16{8'h63}});

    // R6 drop and R7 hold with inputs moving
    held = state_o;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk_i);
      state_i = {rnd128(), rnd128(), rnd128(), rnd128(), rnd128()};
      msg_i = rnd128();
      chk("R6 valid_o low", WW'(valid_o), '0);
      for (int k = 0; k < NW; k++) chk("R7 hold", state_o[k*WW +: WW], held[k*WW +: WW]);
    end

    // R2/R3 random
    for (int t = 0; t < N_RAND; t++) begin
      s = {rnd128(), rnd128(), rnd128(), rnd128(), rnd128()};
      m = (t % 10 == 0) ? '1 : rnd128();
      step(s, m);
      chk_state(update_ref(s, m));
    end

    // R8 asynchronous reset mid-run
    step({rnd128(), rnd128(), rnd128(), rnd128(), rnd128()}, rnd128());
    #3 rst_ni = 1'b0;
    #1;
    chk("R8 async valid_o", WW'(valid_o), '0);
    for (int k = 0; k < NW; k++) chk("R8 async state_o", state_o[k*WW +: WW], '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule